// File: doc/BRIEF.md
# Wavetable Sound Channel

This block is one voice of a simple sound generator. It plays a looping waveform of 32 four-bit samples. The samples are packed two to a byte in a 16-byte register file. A fixed reference clock reaches the block as a one-cycle strobe, `ref_tick`. A 16-bit period register divides that strobe to set the sample rate, so the rate is the reference frequency divided by the period value. A period of zero stops the channel. Each new sample is registered onto a 4-bit output that feeds a DAC.

A control register holds a master enable, a DAC enable and one enable per generator. The parameter `CHAN` picks which generator bit this voice obeys. The enables are looked at only when a pass through the waveform ends. The voice then starts a new pass if both the master enable and its own bit are set. If either is clear, it stays finished and keeps driving the last sample. A second output carries an 8-bit raw DAC value. The block loads that output only in the DAC-only control mode.

All configuration goes through one byte-wide write port. The write port and the strobe are sampled on the rising clock edge.

Top module: `wtc_channel`

## Requirements
- R1: On synchronous active-high reset, `sample_out` and `dac_out` become 0, and the control, period and waveform registers clear to 0.
- R2: Address 0x11 writes bits 15:8 of the period and address 0x12 writes bits 7:0. Each write leaves the other half unchanged.
- R3: With a nonzero period P, a sample step happens on every P-th `ref_tick`. The first `ref_tick` seen after the period was zero (or after reset) is a step. `sample_out` takes the new sample on the same clock edge that samples that `ref_tick`.
- R4: While the period is zero, no step happens and `sample_out` holds its value.
- R5: Waveform bytes sit at addresses 0x00 to 0x0F. Sample n (0 to 31) comes from byte n/2: an even n uses bits 3:0 and an odd n uses bits 7:4. Samples play in increasing n.
- R6: The control register is at address 0x10: bit 7 is the master enable, bit 3 the DAC enable, and bits 2, 1 and 0 are the generator enables. When a step comes after sample 31 has been played, playback restarts at sample 0 on that step only if bit 7 and bit `CHAN` are both 1. Otherwise the channel stays finished and `sample_out` holds the last sample.
- R7: After reset the channel is finished. It plays nothing until a step comes while the enables of R6 are set.
- R8: A new period value takes effect at the next reload of the divider. The step already counting down keeps the old length.
- R9: A write to address 0x13 loads `dac_out` on the next edge only when (control AND 0x8F) equals 0x88. In any other mode, and with any other write, `dac_out` is unchanged.
- R10: A step in the same cycle as a control or period write uses the register values from before that write.
- R11: Clearing an enable in the middle of a pass does not stop it. The remaining samples of the pass still play.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| sample_out | output | 4 | Current waveform sample to the DAC |
| dac_out | output | 8 | Raw DAC value from the direct path |

## Verification
Two functions can fall in the same cycle: a divider reload or the end-of-waveform restart decision, and a write to the period or control register. The bench drives a pseudo-random stream of strobes together with writes of period bytes and control values that switch the enables on and off. Many writes therefore land on the exact edge of a step. A behavioural model applies the step before the write, as R10 requires, and the bench compares both outputs with the model on every clock.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int PERIOD_W = 16;
    localparam int ADDR_W   = 5;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h10;
    localparam logic [ADDR_W-1:0] A_PER_HI = 5'h11;
    localparam logic [ADDR_W-1:0] A_PER_LO = 5'h12;
    localparam logic [ADDR_W-1:0] A_DIRECT = 5'h13;

    localparam logic [BYTE_W-1:0] DIRECT_MASK  = 8'h8F;
    localparam logic [BYTE_W-1:0] DIRECT_MATCH = 8'h88;

    typedef struct packed {
        logic       master;
        logic [2:0] spare;
        logic       dac_on;
        logic [2:0] gen_on;
    } ctrl_t;

    function automatic logic [NIB_W-1:0] pick_nib(input logic [BYTE_W-1:0] b,
                                                  input logic upper);
        return upper ? b[BYTE_W-1 -: NIB_W] : b[NIB_W-1:0];
    endfunction
endpackage

// File: rtl/wtc_regs.sv
module wtc_regs
    import wtc_pkg::*;
#(
    parameter int WAVE_BYTES = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [BYTE_W-1:0]                   wr_data,
    output logic [WAVE_BYTES-1:0][BYTE_W-1:0]   wave_o,
    output ctrl_t                               ctrl_o,
    output logic [PERIOD_W-1:0]                 period_o,
    output logic [BYTE_W-1:0]                   direct_o
);
    logic [WAVE_BYTES-1:0][BYTE_W-1:0] wave_q;
    ctrl_t                             ctrl_q;
    logic [PERIOD_W-1:0]               per_q;
    logic [BYTE_W-1:0]                 dir_q;
    logic                              direct_mode;

    assign direct_mode = ((ctrl_q & DIRECT_MASK) == DIRECT_MATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < WAVE_BYTES; i++) begin
                if (wr_addr == ADDR_W'(i)) wave_q[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:   ctrl_q <= ctrl_t'(wr_data);
                A_PER_HI: per_q[PERIOD_W-1 -: BYTE_W] <= wr_data;
                A_PER_LO: per_q[BYTE_W-1:0] <= wr_data;
                A_DIRECT: if (direct_mode) dir_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign wave_o   = wave_q;
    assign ctrl_o   = ctrl_q;
    assign period_o = per_q;
    assign direct_o = dir_q;
endmodule

// File: rtl/wtc_divider.sv
module wtc_divider
    import wtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                step
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                reload;

    assign reload = (cnt_q <= PERIOD_W'(1));
    assign step   = tick && (period != '0) && reload;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (period == '0)  cnt_q <= '0;
            else if (reload)   cnt_q <= period;
            else               cnt_q <= cnt_q - PERIOD_W'(1);
        end
    end

    // R8: a count that is still running only goes down
    p_count_descends_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick) && !$past(step) && !step && period != '0 && $past(period) != '0)
            |-> (cnt_q < $past(cnt_q)) || !$past(tick));
endmodule

// File: rtl/wtc_sequencer.sv
module wtc_sequencer
    import wtc_pkg::*;
#(
    parameter int WAVE_BYTES = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              step,
    input  logic                              restart_ok,
    input  logic [WAVE_BYTES-1:0][BYTE_W-1:0] wave,
    output logic [NIB_W-1:0]                  smp_o
);
    localparam int SAMPLES = 2 * WAVE_BYTES;
    localparam int IDX_W   = $clog2(SAMPLES);
    localparam int POS_W   = IDX_W + 1;
    localparam logic [POS_W-1:0] DONE = POS_W'(SAMPLES);

    logic [POS_W-1:0]  pos_q;
    logic [NIB_W-1:0]  smp_q;
    logic [IDX_W-1:0]  play_idx;
    logic [BYTE_W-1:0] cur_byte;
    logic              finished;

    assign finished = (pos_q == DONE);
    assign play_idx = finished ? '0 : pos_q[IDX_W-1:0];
    assign cur_byte = wave[play_idx[IDX_W-1:1]];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= DONE;
            smp_q <= '0;
        end else if (step && (!finished || restart_ok)) begin
            smp_q <= pick_nib(cur_byte, play_idx[0]);
            pos_q <= POS_W'(play_idx) + POS_W'(1);
        end
    end

    assign smp_o = smp_q;

    p_pos_bound_r5: assert property (@(posedge clk) disable iff (rst)
        pos_q <= DONE);
    p_hold_without_step_r7: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(smp_q));
    p_finished_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (finished && step && !restart_ok) |=> (pos_q == DONE) && $stable(smp_q));
endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
    import wtc_pkg::*;
#(
    parameter int CHAN       = 0,
    parameter int WAVE_BYTES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ref_tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [NIB_W-1:0]    sample_out,
    output logic [BYTE_W-1:0]   dac_out
);
    logic [WAVE_BYTES-1:0][BYTE_W-1:0] wave;
    ctrl_t                             ctrl;
    logic [PERIOD_W-1:0]               period;
    logic                              step;
    logic                              restart_ok;

    wtc_regs #(.WAVE_BYTES(WAVE_BYTES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wave_o(wave), .ctrl_o(ctrl), .period_o(period), .direct_o(dac_out)
    );

    wtc_divider u_div (
        .clk(clk), .rst(rst), .tick(ref_tick), .period(period), .step(step)
    );

    assign restart_ok = ctrl.master && ctrl.gen_on[CHAN];

    wtc_sequencer #(.WAVE_BYTES(WAVE_BYTES)) u_seq (
        .clk(clk), .rst(rst), .step(step), .restart_ok(restart_ok),
        .wave(wave), .smp_o(sample_out)
    );

    p_zero_period_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |-> !step);
    p_dac_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_DIRECT) |=> $stable(dac_out));
endmodule

// File: tb/tb_wtc_channel.sv
module tb_wtc_channel;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       ref_tick = 0;
    logic       wr_en = 0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] sample_out;
    logic [7:0] dac_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    wtc_channel dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sample_out(sample_out), .dac_out(dac_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int mwave[16];
    int mctrl, mper, mdac, mcnt, mpos, msmp;

    function automatic int nib(int n);
        return (n % 2) ? (mwave[n/2] >> 4) & 15 : mwave[n/2] & 15;
    endfunction

    always @(posedge clk) begin
        bit ev;
        ev = 0;
        if (rst) begin
            foreach (mwave[i]) mwave[i] = 0;
            mctrl = 0; mper = 0; mdac = 0; mcnt = 0; mpos = 32; msmp = 0;
        end else begin
            if (ref_tick) begin
                if (mper == 0) mcnt = 0;
                else if (mcnt <= 1) begin ev = 1; mcnt = mper; end
                else mcnt = mcnt - 1;
            end
            if (ev) begin
                if (mpos == 32) begin
                    if (mctrl[7] && mctrl[0]) begin msmp = nib(0); mpos = 1; end
                end else begin
                    msmp = nib(mpos); mpos = mpos + 1;
                end
            end
            if (wr_en) begin
                if (wr_addr < 16) mwave[wr_addr] = wr_data;
                else if (wr_addr == 5'h10) mctrl = wr_data;
                else if (wr_addr == 5'h11) mper = (mper & 255) | (int'(wr_data) << 8);
                else if (wr_addr == 5'h12) mper = (mper & 65280) | int'(wr_data);
                else if (wr_addr == 5'h13 && (mctrl & 8'h8F) == 8'h88) mdac = wr_data;
            end
        end
    end

    bit cmp_on = 0;
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            checks++;
            if (sample_out !== 4'(msmp)) begin
                errors++;
                $display("FAIL %s sample_out actual=%0d expected=%0d t=%0t", tag, sample_out, msmp, $time);
            end
            checks++;
            if (dac_out !== 8'(mdac)) begin
                errors++;
                $display("FAIL %s dac_out actual=%0h expected=%0h t=%0t", tag, dac_out, mdac, $time);
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic cyc(input bit we, input logic [4:0] a, input logic [7:0] d, input bit tk);
        wr_en = we; wr_addr = a; wr_data = d; ref_tick = tk;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit every_other);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, every_other ? (i % 2 == 0) : 1'b1);
    endtask

    task automatic expect_now(input logic [3:0] s, input string r);
        checks++;
        if (sample_out !== s) begin
            errors++;
            $display("FAIL %s directed sample actual=%0d expected=%0d", r, sample_out, s);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        // R1: reset state
        tag = "R1";
        expect_now(4'd0, "R1");
        // load waveform: low nibble = i, high nibble = i^5
        for (int i = 0; i < 16; i++) cyc(1, 5'(i), {4'(i ^ 5), 4'(i)}, 0);
        // R4: ticks with period zero
        tag = "R4";
        idle(20, 0);
        expect_now(4'd0, "R4");
        // R7: period set, enables off: finished, nothing plays
        tag = "R7";
        cyc(1, 5'h12, 8'd3, 0);
        idle(30, 0);
        expect_now(4'd0, "R7");
        // R6: only channel-1 bit set does not restart channel 0
        tag = "R6";
        cyc(1, 5'h10, 8'h82, 0);
        idle(30, 0);
        expect_now(4'd0, "R6");
        // R5/R3: play with master + gen0
        tag = "R5";
        cyc(1, 5'h10, 8'h81, 0);
        idle(120, 1);
        tag = "R3";
        cyc(1, 5'h12, 8'd1, 0);
        idle(80, 0);
        // R8: change period mid-run
        tag = "R8";
        cyc(1, 5'h12, 8'd5, 1);
        idle(60, 0);
        // R2: high byte only, then low byte only
        tag = "R2";
        cyc(1, 5'h11, 8'h01, 0);
        cyc(1, 5'h12, 8'h02, 0);
        idle(700, 0);
        cyc(1, 5'h11, 8'h00, 0);
        idle(300, 0);
        // R4: period zero mid-pass holds
        tag = "R4";
        cyc(1, 5'h12, 8'h00, 1);
        idle(40, 0);
        // R11/R6: clear enables mid-pass, the pass completes then holds last sample
        tag = "R11";
        cyc(1, 5'h12, 8'd1, 0);
        idle(5, 0);
        cyc(1, 5'h10, 8'h80, 1);
        idle(40, 0);
        tag = "R6";
        idle(40, 0);
        expect_now(4'd10, "R6");
        // R9: direct DAC path
        tag = "R9";
        cyc(1, 5'h10, 8'h88, 0);
        cyc(1, 5'h13, 8'hA5, 0);
        cyc(0, '0, '0, 0);
        checks++;
        if (dac_out !== 8'hA5) begin errors++; $display("FAIL R9 dac actual=%0h expected=a5", dac_out); end
        cyc(1, 5'h10, 8'h89, 0);
        cyc(1, 5'h13, 8'h3C, 0);
        cyc(1, 5'h10, 8'h08, 0);
        cyc(1, 5'h13, 8'h3C, 0);
        cyc(1, 5'h10, 8'hC8, 0);
        cyc(1, 5'h13, 8'h5A, 0);
        cyc(1, 5'h1F, 8'hFF, 0);
        idle(3, 0);
        // R10: random collisions of writes with steps and restarts
        tag = "R10";
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            bit we;
            logic [4:0] a;
            logic [7:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            we = 0; a = '0; d = '0;
            if (lfsr[4:2] == 3'd0) begin
                we = 1; a = 5'h10;
                case (lfsr[6:5])
                    2'd0: d = 8'h81;
                    2'd1: d = 8'h80;
                    2'd2: d = 8'h01;
                    default: d = 8'h83;
                endcase
            end else if (lfsr[4:2] == 3'd1) begin
                we = 1; a = 5'h12; d = 8'(lfsr[9:8]);
            end
            cyc(we, a, d, lfsr[0] | lfsr[1]);
        end
        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule